// File: doc/BRIEF.md
# Mesochronous Link Receive Synchronizer

This block receives flits from a point-to-point link whose sender runs at the same frequency as the local clock but at an unknown, fixed phase. The link carries a data word and a strobe. The strobe toggles once per sender cycle, so it runs at half the core rate, and each of its edges marks one flit. Both strobe edges write the flit into a four-slot ring. The slot follows a 2-bit write position that advances by one on every edge.

The local side waits for the first strobe rising edge after reset. It then waits a short programmed spacing and from that point reads one ring slot every local cycle, in write order. The spacing is picked once, at start-up. A phase-detect input asks for the wider spacing when the strobe edges fall close to the local clock edge. A low-latency configuration bit removes one cycle from whichever spacing was picked. The block is placed at every link port of a router, and the link must stream one flit per cycle once it has started.

Top module: `meso_rx_sync`

## Requirements
- R1: While reset is held, `out_valid` is 0 and `out_data` is all zeros.
- R2: Each rising and each falling edge of `strb` stores the current `lnk_data` in the next ring slot. After reset the first rising edge fills slot 0, the following falling edge fills slot 1, and so on through slot 3 before the ring wraps back to slot 0.
- R3: The spacing L is 2 when `phase_late` is 1 and 1 when it is 0, less 1 when `fast_mode` is 1, so L ranges from 0 to 2. `out_valid` first rises at the (L+2)-th local rising edge after the first `strb` rising edge that follows reset.
- R4: From the first valid cycle on, each local cycle presents the next flit in arrival order, with no flit dropped or repeated, as long as the link delivers one flit per cycle.
- R5: `phase_late` and `fast_mode` are sampled only at the local edge that first sees a write. Changing them afterwards has no effect on latency or data.
- R6: Each flit reaches `out_data` with all W bits unchanged, for any data pattern and any sender phase within the cycle.
- R7: Once `out_valid` has risen it stays high until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local core clock |
| rst_n | input | 1 | Active-low asynchronous reset for both sides |
| strb | input | 1 | Delayed link strobe; each edge marks one flit |
| lnk_data | input | W (38) | Link data word |
| phase_late | input | 1 | Phase-detect result: 1 when strobe edges fall near the local edge |
| fast_mode | input | 1 | Low-latency configuration: shortens the spacing by one cycle |
| out_data | output | W (38) | Flit in the local clock domain |
| out_valid | output | 1 | High while `out_data` carries a flit |

## Verification
The bench sweeps the sender phase across the local cycle and runs every combination of `phase_late` and `fast_mode` at each phase. The sweep includes the case with zero spacing, where a read follows its write by less than a cycle, and the case with the widest spacing, where the write that overwrites a slot comes only a fraction of a cycle after that slot is read. A design with the wrong spacing would miss the expected first-valid cycle. A design that reads too late would show an entry from the next trip around the ring, and one that reads too early would show stale or zero data. A write position that ignores one strobe edge would skip or repeat flits in the output stream. Both configuration inputs are flipped after start-up, so a design that keeps watching them would shift its latency. Long runs cover several wraps of the ring.

// File: rtl/meso_rx_sync.sv
module meso_rx_sync #(
  parameter int W     = 38,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         strb,
  input  logic [W-1:0] lnk_data,
  input  logic         phase_late,
  input  logic         fast_mode,
  output logic [W-1:0] out_data,
  output logic         out_valid
);
  localparam int HALF = DEPTH / 2;
  localparam int HW   = $clog2(HALF);
  localparam int PW   = $clog2(DEPTH);

  logic [W-1:0]  bank_e [HALF];
  logic [W-1:0]  bank_o [HALF];
  logic [HW-1:0] wp_e, wp_o;
  logic          wr_seen;

  // rising strobe edges fill even slots, falling edges fill odd slots
  always_ff @(posedge strb or negedge rst_n)
    if (!rst_n) begin
      wp_e    <= '0;
      wr_seen <= 1'b0;
    end else begin
      bank_e[wp_e] <= lnk_data;
      wp_e         <= wp_e + 1'b1;
      wr_seen      <= 1'b1;
    end

  always_ff @(negedge strb or negedge rst_n)
    if (!rst_n) wp_o <= '0;
    else begin
      bank_o[wp_o] <= lnk_data;
      wp_o         <= wp_o + 1'b1;
    end

  logic          started;
  logic [1:0]    cnt;
  logic [PW-1:0] rp;

  wire [1:0] lag = (phase_late ? 2'd2 : 2'd1) - {1'b0, fast_mode};
  wire       run = started && (cnt == 2'd0);
  wire [W-1:0] rd_word = rp[0] ? bank_o[rp[PW-1:1]] : bank_e[rp[PW-1:1]];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      started   <= 1'b0;
      cnt       <= 2'd0;
      rp        <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      if (!started && wr_seen) begin
        started <= 1'b1;
        cnt     <= lag;
      end else if (started && cnt != 2'd0) begin
        cnt <= cnt - 2'd1;
      end
      out_valid <= run;
      if (run) begin
        out_data <= rd_word;
        rp       <= rp + 1'b1;
      end
    end

  p_valid_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> out_valid);

  p_no_early_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_seen |-> !out_valid);

  p_spacing_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    started |-> cnt <= 2'd2);

  p_count_down_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (started && cnt != 2'd0) |=> cnt == $past(cnt) - 2'd1);

  p_read_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> rp == $past(rp) + 1'b1);
endmodule

// File: tb/sim_meso_rx_sync.sv
`timescale 1ns/100ps
module sim_meso_rx_sync;
  localparam int W = 38;

  logic clk = 1'b0;
  logic rst_n, strb, phase_late, fast_mode;
  logic [W-1:0] lnk_data, out_data;
  logic out_valid;
  int n_chk = 0, n_bad = 0;
  logic [W-1:0] exp_q [64];
  bit go;

  always #2.5 clk = ~clk;

  meso_rx_sync #(.W(W), .DEPTH(4)) u0 (
    .clk(clk), .rst_n(rst_n), .strb(strb), .lnk_data(lnk_data),
    .phase_late(phase_late), .fast_mode(fast_mode),
    .out_data(out_data), .out_valid(out_valid));

  function automatic int exp_lag(bit late, bit fast);
    return (late ? 2 : 1) - (fast ? 1 : 0);
  endfunction

  task automatic chk(bit ok, string req, logic [W-1:0] act, logic [W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic run(bit late, bit fast, realtime d, int n);
    int cnt;
    bit found;
    rst_n = 1'b0; strb = 1'b0; go = 1'b0;
    phase_late = late; fast_mode = fast; lnk_data = '0;
    for (int k = 0; k < n + 9; k++) exp_q[k] = {$urandom, $urandom};
    repeat (2) @(posedge clk);
    #1;
    chk(out_valid == 1'b0 && out_data == '0, "R1 reset", {out_valid, out_data}, '0);
    rst_n = 1'b1;
    lnk_data = exp_q[0];
    @(posedge clk);
    #(d);
    fork
      begin
        for (int k = 0; k < n + 8; k++) begin
          strb = ~strb;
          if (k == 0) go = 1'b1;
          if (k == 1) begin phase_late = ~late; fast_mode = ~fast; end
          #2 lnk_data = exp_q[k+1];
          #3;
        end
      end
      begin
        wait (go);
        cnt = 0; found = 1'b0;
        for (int i = 0; i < 8; i++) begin
          if (!found) begin
            @(posedge clk); cnt++;
            @(negedge clk);
            if (out_valid) found = 1'b1;
          end
        end
        chk(found && cnt == exp_lag(late, fast) + 2, "R3 R5 first-valid cycle",
            W'(cnt), W'(exp_lag(late, fast) + 2));
        for (int k = 0; k < n; k++) begin
          if (k > 0) @(negedge clk);
          chk(out_valid && out_data == exp_q[k], "R2 R4 R6 R7 flit stream",
              out_data, exp_q[k]);
        end
      end
    join
  endtask

  initial begin
    #1ms;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    realtime ph [5] = '{0.5, 1.5, 2.5, 3.5, 4.5};
    void'($urandom(32'd77));
    // directed extremes: zero spacing near the edge, widest spacing late in cycle
    run(1'b0, 1'b1, 0.5, 12);
    run(1'b1, 1'b0, 4.5, 12);
    for (int p = 0; p < 5; p++)
      for (int c = 0; c < 4; c++)
        run(c[1], c[0], ph[p], 20);
    // long stream, many ring wraps
    run(1'b1, 1'b1, 2.0, 40);
    run(1'b0, 1'b0, 3.0, 40);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule